// File: doc/BRIEF.md
# SDRAM Cycle Sequencer and Command Driver

This block sits between a processor, an initialization controller and a refresh timer on one side and a pair of SDRAM regions on the other. When it is idle it takes one request, choosing refresh first, then an initialization command, then a processor access. It then steps through the chosen cycle with a 2-bit cycle-type register and a 4-bit step counter. A single decoder turns that pair into every SDRAM pin value, so all command and mask timing comes from one counter. A 25-bit word-aligned processor address is split into a region select, a bank, a 12-bit row and an 8-bit column. Each of the two 16 MB regions is organized as 4M x 32 and has its own chip select.

The block has no data path. The processor asserts its select low and holds it until the cycle type reads data (10). It then releases the select and watches the active-low acknowledge, which frames the four beats. If the select is still held when the next idle clock arrives, a second access starts. The initialization and refresh requesters follow the same rule: a request still high on an idle clock is taken again. Every read and write requests auto-precharge, so no row is left open. An active-low terminate input cuts a burst short.

Top module: `sdram_cycle_seq`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the outputs are: cycle type 00, step 0, both chip selects high, RAS/CAS/WE high, address and bank 0, DQM 1111, acknowledge high, CKE high. A reset applied in the middle of a cycle returns the block to this state on the next clock.
- R2: A request is accepted only on a clock where the cycle type is idle. Priority is refresh request, then initialization request, then processor select (low). At least one idle clock separates two cycles.
- R3: A refresh cycle has cycle type 11. At step 0 it drives the refresh command (RAS=0, CAS=0, WE=1) on both chip selects together. Steps 1 to 7 are inhibit (both chip selects high). The block is idle on the following clock.
- R4: A command cycle has cycle type 01 and issues the latched operation at step 0 on both chip selects. The operation codes are 00 NOP (1,1,1), 01 precharge-all (0,1,0) with address bit 10 high, 10 refresh (0,0,1), and 11 load-mode (0,0,0) with the address carrying the 12-bit mode value. Steps 1 to 3 are inhibit, and the block is idle on the following clock.
- R5: A data cycle has cycle type 10. At step 0 it drives activate (0,1,1) on chip select 0 when address bit 24 is 0, or on chip select 1 when it is 1. The bank comes from address bits 23:22 and the row from address bits 21:10.
- R6: At step 2 of a data cycle the block drives a write (1,0,0) when the write strobe was low at acceptance, and a read (1,0,1) otherwise. The same chip select and bank are used. The address carries column bits 9:2 in bits 7:0, bit 10 high for auto-precharge, and all other bits 0.
- R7: DQM equals the inverse of the byte enables latched at acceptance during data-cycle steps 2 to 5. At every other time it is 1111.
- R8: The acknowledge is low during steps 2 to 5 of a write and steps 4 to 7 of a read (CAS latency 2). It is high at every other time.
- R9: A data cycle lasts 10 clocks (steps 0 to 9), after which the block is idle.
- R10: If terminate is low on a clock edge while the acknowledge is low and the current step is not the last beat, the next step drives burst-terminate (1,1,0) on the cycle's chip select. From that step onward, acknowledge stays high and DQM stays at 1111. The cycle still ends at step 9. Terminate sampled at any other time has no effect.
- R11: Within a cycle the step counter rises by one each clock. The cycle type holds until the cycle's last step.
- R12: On every step that issues no command, both chip selects are high, RAS/CAS/WE are high, and the address and bank are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel_n | input | 1 | Processor access request, active low |
| cpu_wr_n | input | 1 | Low selects write, high selects read |
| cpu_term_n | input | 1 | Burst terminate, active low |
| cpu_addr | input | 25 | Word-aligned processor byte address |
| cpu_be | input | 4 | Byte-lane enables, active high |
| init_req | input | 1 | Initialization command request |
| init_op | input | 2 | Initialization operation code |
| mode_val | input | 12 | Mode value for load-mode |
| rfsh_req | input | 1 | Refresh request |
| cyc_type | output | 2 | Current cycle type |
| cyc_step | output | 4 | Position within the cycle |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 2 | Chip selects, bit 0 lower region, bit 1 upper region |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write strobe |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | SDRAM address |
| sd_dqm | output | 4 | Data mask per lane |
| cpu_ack_n | output | 1 | Data beat acknowledge, active low |

## Verification
The bench targets simultaneous requests, where wrong priority would run a data or command cycle ahead of a pending refresh. It also uses addresses with every field at its extremes: a wrong bit slice would put the bank, row or column on the wrong pins, or select the wrong chip. Terminate is driven inside the beat window, on the last beat and outside the window. A design that mishandled these cases would either skip the burst-terminate command, issue it on a step where it ends nothing, or leave the acknowledge and mask active afterwards. A reset in the middle of a cycle checks that no cycle state survives it.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'b00,
    CYC_CMD  = 2'b01,
    CYC_DATA = 2'b10,
    CYC_RFSH = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_PRE = 2'b01,
    OP_REF = 2'b10,
    OP_LMR = 2'b11
  } op_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] K_NOP = 3'b111;
  localparam logic [2:0] K_ACT = 3'b011;
  localparam logic [2:0] K_RD  = 3'b101;
  localparam logic [2:0] K_WR  = 3'b100;
  localparam logic [2:0] K_BST = 3'b110;
  localparam logic [2:0] K_PRE = 3'b010;
  localparam logic [2:0] K_REF = 3'b001;
  localparam logic [2:0] K_LMR = 3'b000;

endpackage

// File: rtl/sdseq_ctl.sv
module sdseq_ctl
  import sdseq_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int BE_W    = 4,
  parameter int STEP_W  = 4,
  parameter int TRCD    = 2,
  parameter int CAS_LAT = 2,
  parameter int BURST   = 4,
  parameter int TRP     = 2,
  parameter int TRC     = 7,
  parameter int CMD_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfsh_req,
  input  logic              init_req,
  input  logic [1:0]        init_op,
  input  logic              cpu_sel_n,
  input  logic              cpu_wr_n,
  input  logic              cpu_term_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]   cpu_be,
  output cyc_e              cyc,
  output logic [STEP_W-1:0] step,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic [BE_W-1:0]   be_q,
  output logic              term_q,
  output logic              bst_q,
  output logic              beat_on,
  output logic              mask_on
);

  localparam logic [STEP_W-1:0] S_WR0   = STEP_W'(TRCD);
  localparam logic [STEP_W-1:0] S_RD0   = STEP_W'(TRCD + CAS_LAT);
  localparam logic [STEP_W-1:0] S_BM1   = STEP_W'(BURST - 1);
  localparam logic [STEP_W-1:0] S_DLAST = STEP_W'(TRCD + CAS_LAT + BURST - 1 + TRP);
  localparam logic [STEP_W-1:0] S_RLAST = STEP_W'(TRC);
  localparam logic [STEP_W-1:0] S_CLAST = STEP_W'(CMD_LEN - 1);

  logic [STEP_W-1:0] first_s, last_s;
  logic              beat_end;

  assign first_s  = wr_q ? S_WR0 : S_RD0;
  assign beat_on  = (cyc == CYC_DATA) && (step >= first_s) && (step <= first_s + S_BM1);
  assign beat_end = (step == first_s + S_BM1);
  assign mask_on  = (cyc == CYC_DATA) && (step >= S_WR0) && (step <= S_WR0 + S_BM1);

  always_comb begin
    case (cyc)
      CYC_DATA: last_s = S_DLAST;
      CYC_RFSH: last_s = S_RLAST;
      CYC_CMD:  last_s = S_CLAST;
      default:  last_s = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= CYC_IDLE;
      step   <= '0;
      op_q   <= OP_NOP;
      addr_q <= '0;
      wr_q   <= 1'b0;
      be_q   <= '0;
      term_q <= 1'b0;
      bst_q  <= 1'b0;
    end else begin
      bst_q <= 1'b0;
      if (cyc == CYC_IDLE) begin
        step   <= '0;
        term_q <= 1'b0;
        if (rfsh_req) begin
          cyc <= CYC_RFSH;
        end else if (init_req) begin
          cyc  <= CYC_CMD;
          op_q <= op_e'(init_op);
        end else if (!cpu_sel_n) begin
          cyc    <= CYC_DATA;
          addr_q <= cpu_addr;
          wr_q   <= !cpu_wr_n;
          be_q   <= cpu_be;
        end
      end else if (step == last_s) begin
        cyc    <= CYC_IDLE;
        step   <= '0;
        term_q <= 1'b0;
      end else begin
        step <= step + STEP_W'(1);
        if (beat_on && !beat_end && !cpu_term_n && !term_q) begin
          term_q <= 1'b1;
          bst_q  <= 1'b1;
        end
      end
    end
  end

  // R2: refresh wins whenever it is pending on an idle clock
  a_r2_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_IDLE && rfsh_req) |=> (cyc == CYC_RFSH));

  // R2/R11: a running cycle keeps its type until its last step
  a_r11_type_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != CYC_IDLE && step != last_s) |=> (cyc == $past(cyc)));

  // R11: step advances by one inside a cycle
  a_r11_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != CYC_IDLE && step != last_s) |=> (step == $past(step) + STEP_W'(1)));

  // R9: last step is followed by idle
  a_r9_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != CYC_IDLE && step == last_s) |=> (cyc == CYC_IDLE && step == '0));

endmodule

// File: rtl/sdseq_pins.sv
module sdseq_pins
  import sdseq_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int BE_W    = 4,
  parameter int STEP_W  = 4,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int TRCD    = 2,
  parameter int CAS_LAT = 2,
  parameter int AP_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic [STEP_W-1:0] step,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              wr_q,
  input  logic [BE_W-1:0]   be_q,
  input  logic              term_q,
  input  logic              bst_q,
  input  logic              beat_on,
  input  logic              mask_on,
  input  logic [ROW_W-1:0]  mode_val,
  output logic [(1<<(ADDR_W-$clog2(BE_W)-COL_W-ROW_W-BANK_W))-1:0] sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  output logic              ack_n
);

  localparam int COL_LO  = $clog2(BE_W);
  localparam int ROW_LO  = COL_LO + COL_W;
  localparam int BANK_LO = ROW_LO + ROW_W;
  localparam int REG_LO  = BANK_LO + BANK_W;
  localparam int REG_W   = ADDR_W - REG_LO;
  localparam int NREG    = 1 << REG_W;
  localparam logic [STEP_W-1:0] S_CMD2 = STEP_W'(TRCD);

  logic [NREG-1:0]   reg_sel, sel;
  logic [2:0]        cmd;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row, col_a;

  for (genvar r = 0; r < NREG; r++) begin : g_region
    assign reg_sel[r] = (addr_q[ADDR_W-1:REG_LO] == REG_W'(r));
  end

  assign bank = addr_q[BANK_LO +: BANK_W];
  assign row  = addr_q[ROW_LO +: ROW_W];

  always_comb begin
    col_a = '0;
    col_a[COL_W-1:0] = addr_q[COL_LO +: COL_W];
    col_a[AP_BIT] = 1'b1;
  end

  always_comb begin
    cmd  = K_NOP;
    sel  = '0;
    sd_a = '0;
    sd_ba = '0;
    case (cyc)
      CYC_RFSH: if (step == '0) begin
        cmd = K_REF;
        sel = '1;
      end
      CYC_CMD: if (step == '0) begin
        sel = '1;
        case (op_q)
          OP_PRE: begin cmd = K_PRE; sd_a[AP_BIT] = 1'b1; end
          OP_REF: cmd = K_REF;
          OP_LMR: begin cmd = K_LMR; sd_a = mode_val; end
          default: cmd = K_NOP;
        endcase
      end
      CYC_DATA: begin
        if (bst_q) begin
          cmd = K_BST;
          sel = reg_sel;
        end else if (step == '0) begin
          cmd   = K_ACT;
          sel   = reg_sel;
          sd_ba = bank;
          sd_a  = row;
        end else if (step == S_CMD2) begin
          cmd   = wr_q ? K_WR : K_RD;
          sel   = reg_sel;
          sd_ba = bank;
          sd_a  = col_a;
        end
      end
      default: ;
    endcase
  end

  assign sd_cs_n = ~sel;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = (sel != '0) ? cmd : K_NOP;
  assign sd_dqm  = (mask_on && !term_q) ? ~be_q : '1;
  assign ack_n   = !(beat_on && !term_q);

  // R8: read acknowledge opens CAS_LAT clocks after the read command
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n) && !wr_q) |-> $past(sd_ras_n && !sd_cas_n && sd_we_n, CAS_LAT));

  // R10: after a burst terminate the acknowledge stays high
  a_r10_bst_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ((sd_cs_n != '1) && sd_ras_n && sd_cas_n && !sd_we_n) |=> ack_n);

  // R3: both chip selects together never happen in a data cycle
  a_r3_dual_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n == '0) |-> (cyc != CYC_DATA));

  // R7: masks open only while some lane qualifier window is running
  a_r7_mask_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_dqm != '1) |-> (cyc == CYC_DATA));

endmodule

// File: rtl/sdram_cycle_seq.sv
module sdram_cycle_seq
  import sdseq_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int BE_W    = 4,
  parameter int STEP_W  = 4,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int NCS     = 2,
  parameter int TRCD    = 2,
  parameter int CAS_LAT = 2,
  parameter int BURST   = 4,
  parameter int TRP     = 2,
  parameter int TRC     = 7,
  parameter int CMD_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel_n,
  input  logic              cpu_wr_n,
  input  logic              cpu_term_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic              init_req,
  input  logic [1:0]        init_op,
  input  logic [ROW_W-1:0]  mode_val,
  input  logic              rfsh_req,
  output logic [1:0]        cyc_type,
  output logic [STEP_W-1:0] cyc_step,
  output logic              sd_cke,
  output logic [NCS-1:0]    sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [BE_W-1:0]   sd_dqm,
  output logic              cpu_ack_n
);

  cyc_e              cyc;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, term_q, bst_q, beat_on, mask_on;
  logic [BE_W-1:0]   be_q;

  sdseq_ctl #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .STEP_W(STEP_W), .TRCD(TRCD),
    .CAS_LAT(CAS_LAT), .BURST(BURST), .TRP(TRP), .TRC(TRC), .CMD_LEN(CMD_LEN)
  ) i_ctl (
    .clk(clk), .rst_n(rst_n), .rfsh_req(rfsh_req), .init_req(init_req),
    .init_op(init_op), .cpu_sel_n(cpu_sel_n), .cpu_wr_n(cpu_wr_n),
    .cpu_term_n(cpu_term_n), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cyc(cyc), .step(cyc_step), .op_q(op_q), .addr_q(addr_q), .wr_q(wr_q),
    .be_q(be_q), .term_q(term_q), .bst_q(bst_q), .beat_on(beat_on),
    .mask_on(mask_on)
  );

  sdseq_pins #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .STEP_W(STEP_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .BANK_W(BANK_W), .TRCD(TRCD), .CAS_LAT(CAS_LAT), .AP_BIT(10)
  ) i_pins (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .step(cyc_step), .op_q(op_q),
    .addr_q(addr_q), .wr_q(wr_q), .be_q(be_q), .term_q(term_q), .bst_q(bst_q),
    .beat_on(beat_on), .mask_on(mask_on), .mode_val(mode_val),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .ack_n(cpu_ack_n)
  );

  assign cyc_type = cyc;
  assign sd_cke   = 1'b1;

endmodule

// File: tb/test_sdram_cycle_seq.sv
`timescale 1ns/1ps
module test_sdram_cycle_seq;

  typedef struct packed {
    logic [24:0] addr;
    logic        wr;
    logic [3:0]  be;
    int          term_at;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{25'h0000004, 1'b1, 4'hF, -1},
    '{25'h1FFFFFC, 1'b0, 4'h5, -1},
    '{25'h0568CF0, 1'b1, 4'hA, 1},
    '{25'h1803E00, 1'b0, 4'h0, 7},
    '{25'h0A5A5A8, 1'b0, 4'h3, 5},
    '{25'h1234568, 1'b1, 4'hC, 3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_sel_n = 1'b1, cpu_wr_n = 1'b1, cpu_term_n = 1'b1;
  logic [24:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic init_req = 1'b0, rfsh_req = 1'b0;
  logic [1:0]  init_op = '0;
  logic [11:0] mode_val = 12'h032;
  logic [1:0]  cyc_type;
  logic [3:0]  cyc_step;
  logic sd_cke, sd_ras_n, sd_cas_n, sd_we_n, cpu_ack_n;
  logic [1:0]  sd_cs_n, sd_ba;
  logic [11:0] sd_a;
  logic [3:0]  sd_dqm;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdram_cycle_seq i_sdram_cycle_seq (
    .clk(clk), .rst_n(rst_n), .cpu_sel_n(cpu_sel_n), .cpu_wr_n(cpu_wr_n),
    .cpu_term_n(cpu_term_n), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .init_req(init_req), .init_op(init_op), .mode_val(mode_val),
    .rfsh_req(rfsh_req), .cyc_type(cyc_type), .cyc_step(cyc_step),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .sd_dqm(sd_dqm), .cpu_ack_n(cpu_ack_n)
  );

  // {type, step, cs_n, ras/cas/we, ba, a, dqm, ack_n, cke}
  function automatic logic [30:0] pk(input logic [1:0] t, input int s,
      input logic [1:0] cs, input logic [2:0] c, input logic [1:0] ba,
      input logic [11:0] a, input logic [3:0] dqm, input logic ack);
    return {t, 4'(s), cs, c, ba, a, dqm, ack, 1'b1};
  endfunction

  function automatic logic [30:0] actual();
    return {cyc_type, cyc_step, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n,
            sd_ba, sd_a, sd_dqm, cpu_ack_n, sd_cke};
  endfunction

  task automatic chk(input string req, input logic [30:0] act, input logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, actual(), pk(2'b00, 0, 2'b11, 3'b111, 2'b00, 12'h000, 4'hF, 1'b1));
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // run a data cycle, checking every step against values from R5-R10, R12
  task automatic run_data(input vec_t v);
    logic [1:0]  csr = v.addr[24] ? 2'b01 : 2'b10;
    logic [1:0]  bank = v.addr[23:22];
    logic [11:0] row = v.addr[21:10];
    logic [11:0] cola = {1'b0, 1'b1, 2'b00, v.addr[9:2]};
    int first = v.wr ? 2 : 4;
    int tb = -1;
    if (v.term_at >= first && v.term_at < first + 3) tb = v.term_at + 1;
    @(negedge clk);
    cpu_sel_n = 1'b0; cpu_wr_n = !v.wr; cpu_addr = v.addr; cpu_be = v.be;
    @(negedge clk);
    cpu_sel_n = 1'b1;
    for (int s = 0; s < 10; s++) begin
      logic [1:0] cs = 2'b11; logic [2:0] c = 3'b111;
      logic [1:0] ba = 2'b00; logic [11:0] a = 12'h000;
      logic stopped = (tb >= 0 && s >= tb);
      logic [3:0] dqm = (s >= 2 && s <= 5 && !stopped) ? ~v.be : 4'hF;
      logic ack = !(s >= first && s <= first + 3 && !stopped);
      string rq = "R7 R8 R10 R12";
      cpu_term_n = !(s == v.term_at);
      if (s == tb) begin cs = csr; c = 3'b110; rq = "R10"; end
      else if (s == 0) begin cs = csr; c = 3'b011; ba = bank; a = row; rq = "R5"; end
      else if (s == 2) begin cs = csr; c = v.wr ? 3'b100 : 3'b101; ba = bank; a = cola; rq = "R6 R7 R8"; end
      chk(rq, actual(), pk(2'b10, s, cs, c, ba, a, dqm, ack));
      @(negedge clk);
    end
    cpu_term_n = 1'b1;
    chk_idle("R9");
  endtask

  task automatic run_cmd(input logic [1:0] op);
    logic [2:0]  c;
    logic [11:0] a = 12'h000;
    case (op)
      2'b01: begin c = 3'b010; a = 12'h400; end
      2'b10: c = 3'b001;
      2'b11: begin c = 3'b000; a = mode_val; end
      default: c = 3'b111;
    endcase
    @(negedge clk);
    init_req = 1'b1; init_op = op;
    @(negedge clk);
    init_req = 1'b0;
    chk("R4", actual(), pk(2'b01, 0, 2'b00, c, 2'b00, a, 4'hF, 1'b1));
    repeat (3) @(negedge clk);
    chk("R4 R12", actual(), pk(2'b01, 3, 2'b11, 3'b111, 2'b00, 12'h000, 4'hF, 1'b1));
    @(negedge clk);
    chk_idle("R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    // table-driven data cycles
    for (int i = 0; i < NV; i++) run_data(VECS[i]);

    // refresh cycle
    @(negedge clk);
    rfsh_req = 1'b1;
    @(negedge clk);
    rfsh_req = 1'b0;
    chk("R3", actual(), pk(2'b11, 0, 2'b00, 3'b001, 2'b00, 12'h000, 4'hF, 1'b1));
    for (int s = 1; s < 8; s++) begin
      @(negedge clk);
      chk("R3 R11 R12", actual(), pk(2'b11, s, 2'b11, 3'b111, 2'b00, 12'h000, 4'hF, 1'b1));
    end
    @(negedge clk);
    chk_idle("R3");

    // initialization commands
    for (int op = 0; op < 4; op++) run_cmd(2'(op));
    mode_val = 12'h5A7;
    run_cmd(2'b11);

    // priority: all three at once
    @(negedge clk);
    rfsh_req = 1'b1; init_req = 1'b1; init_op = 2'b01;
    cpu_sel_n = 1'b0; cpu_wr_n = 1'b0; cpu_addr = 25'h1000000; cpu_be = 4'hF;
    @(negedge clk);
    rfsh_req = 1'b0;
    chk("R2", {30'd0, cyc_type == 2'b11}, 31'd1);
    repeat (3) @(negedge clk);
    chk("R2", {29'd0, cyc_type}, {29'd0, 2'b11});
    repeat (5) @(negedge clk);
    chk_idle("R2");
    @(negedge clk);
    init_req = 1'b0;
    chk("R2", actual(), pk(2'b01, 0, 2'b00, 3'b010, 2'b00, 12'h400, 4'hF, 1'b1));
    repeat (4) @(negedge clk);
    chk_idle("R2");
    @(negedge clk);
    cpu_sel_n = 1'b1;
    chk("R2 R5", actual(), pk(2'b10, 0, 2'b01, 3'b011, 2'b00, 12'h000, 4'hF, 1'b1));

    // reset in mid-cycle
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    run_data('{25'h0C00008, 1'b0, 4'h6, -1});
    report();
  end

endmodule